// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves single words between I/O devices and memory for up to four requesting devices. Each device raises its own request line. The controller picks the highest-priority unmasked request, asks the host for the bus with a hold request, and waits for the acknowledge. It then drives the memory address and the acknowledge line of the selected device, and pulses the read and write strobes for one clock. Finally it steps the channel's address and remaining count. Each request cycle moves exactly one word.

Each channel holds a base address, a base count, a current address and a current count, all 16 bits wide. It also has a three-bit mode and a mask bit. A channel ends its service on terminal count or when the external end-of-process input is low. At that point it either reloads its current registers from the base copies (auto-reload mode) or masks itself. The host programs the channels through a byte-wide register port, and a byte-order toggle sequences the two halves of each 16-bit value. The sequencer has five named one-clock states: IDLE, REQ, ADDR, XFER and UPDT.

Sequencer transitions: IDLE goes to REQ when any unmasked request is present, and the winning channel is latched at that moment. REQ stays in REQ until hold-acknowledge is high, then goes to ADDR. ADDR always goes to XFER. XFER always goes to UPDT. UPDT always returns to IDLE.

Top module: `dma4_ctrl`

## Requirements
- R1: Synchronous reset forces the sequencer to IDLE. While it is in IDLE, hold request, all acknowledges and all strobes are low. Reset also clears every address, count and mode register, sets all four mask bits and clears the byte toggle.
- R2: Register select values 0 to 7 address the channel registers. Bits 2:1 pick the channel. Bit 0 picks the address (0) or the count (1). While the toggle is 0, an access touches the low byte; while it is 1, it touches the high byte. Every such access flips the toggle. A write loads both the base and the current copy, and a read returns the current copy. Writing select 11 clears the toggle. Reading select 12 returns the mask bits in data bits 3:0.
- R3: Writing select 8 sets a channel's mode: data bits 1:0 give the channel, bit 2 the direction, bit 3 decrement and bit 4 auto-reload. Direction 0 (device to memory) pulses the I/O read and memory write strobes. Direction 1 pulses the memory read and I/O write strobes. Writing select 9 sets the mask bit of the channel in data bits 1:0 to the value in data bit 2. Writing select 10 loads all four mask bits from data bits 3:0.
- R4: A request moves the sequencer to REQ, where hold request is high. The sequencer stays in REQ until hold-acknowledge is high. ADDR then drives the acknowledge and the address for one clock. XFER keeps both and raises the strobes for one clock. UPDT follows, and then IDLE, where hold request drops.
- R5: Channel 0 has the highest priority and channel 3 the lowest. At most one acknowledge is high at a time. A request on a masked channel does not raise hold request.
- R6: After each transfer, the current address moves by one, upward or downward as the mode selects and wrapping at 16 bits. The current count drops by one.
- R7: A channel performs one more transfer than its programmed count. Terminal count is the transfer in which the current count is zero, after which the count rolls to all ones. The end-of-process output is high for exactly the UPDT clock of that transfer.
- R8: When service ends on a channel without auto-reload, its mask bit is set and its current registers keep their stepped values.
- R9: When service ends on a channel with auto-reload, its current address and count are reloaded from the base copies and its mask bit stays clear.
- R10: If the external end-of-process input is low during UPDT, service ends as in R8 or R9, but the end-of-process output stays low.
- R11: Host writes and reads have no effect while the sequencer is outside IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 4 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one clock per access |
| host_rd | input | 1 | Host read strobe, one clock per access |
| host_rdata | output | 8 | Host read data (combinational) |
| dreq | input | 4 | Per-channel transfer requests |
| hrq | output | 1 | Hold request to the host |
| hlda | input | 1 | Hold acknowledge from the host |
| dack | output | 4 | Per-channel acknowledge |
| dma_addr | output | 16 | Memory address during ADDR and XFER |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| eop_in_n | input | 1 | External end of process, active low |
| eop_out | output | 1 | Terminal-count pulse |

## Verification
A vector table runs each channel through a chosen mix of settings: direction, step direction, auto-reload, and counts of 0, 1, 2 and 5. The table includes an address that carries from low byte to high byte and one that wraps below zero. Counting transfers up to the end-of-process pulse separates a correct count-plus-one from an off-by-one. The final readback of address, count and mask separates the reload path from the mask-set path. Directed cases follow. Two simultaneous requests show the priority order. All channels masked shows that requests are ignored. The external end-of-process input is driven low with and without auto-reload. Host writes are issued while the controller holds the bus, to show they are ignored.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    localparam int NCH  = 4;
    localparam int CHW  = 2;
    localparam int SELW = 4;

    // Sequencer states, one clock each
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_ADDR = 3'd2,
        ST_XFER = 3'd3,
        ST_UPDT = 3'd4
    } seq_state_t;

    // Per-channel mode bits
    typedef struct packed {
        logic autoinit;
        logic dec;
        logic dir;
    } chan_mode_t;

    // Command select codes (values 0..7 are channel registers)
    localparam logic [SELW-1:0] SEL_MODE    = 4'd8;
    localparam logic [SELW-1:0] SEL_MASK1   = 4'd9;
    localparam logic [SELW-1:0] SEL_MASKALL = 4'd10;
    localparam logic [SELW-1:0] SEL_CLRFF   = 4'd11;
    localparam logic [SELW-1:0] SEL_MASKRD  = 4'd12;

endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hi_byte,
    input  logic                wr_addr,
    input  logic                wr_cnt,
    input  logic [DW-1:0]       wdata,
    input  logic                mode_we,
    input  chan_mode_t          mode_in,
    input  logic                mask_we,
    input  logic                mask_in,
    input  logic                step,
    input  logic                finish,
    output logic [2*DW-1:0]     cur_addr,
    output logic [2*DW-1:0]     cur_cnt,
    output logic                tc,
    output logic                masked
);

    localparam int AW = 2 * DW;
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] base_addr;
    logic [AW-1:0] base_cnt;
    chan_mode_t    mode_q;

    assign tc = (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            mode_q    <= '0;
            masked    <= 1'b1;
        end else begin
            if (wr_addr) begin
                if (hi_byte) begin
                    base_addr[AW-1:DW] <= wdata;
                    cur_addr[AW-1:DW]  <= wdata;
                end else begin
                    base_addr[DW-1:0] <= wdata;
                    cur_addr[DW-1:0]  <= wdata;
                end
            end
            if (wr_cnt) begin
                if (hi_byte) begin
                    base_cnt[AW-1:DW] <= wdata;
                    cur_cnt[AW-1:DW]  <= wdata;
                end else begin
                    base_cnt[DW-1:0] <= wdata;
                    cur_cnt[DW-1:0]  <= wdata;
                end
            end
            if (mode_we) begin
                mode_q <= mode_in;
            end
            if (mask_we) begin
                masked <= mask_in;
            end
            if (step) begin
                if (finish && mode_q.autoinit) begin
                    cur_addr <= base_addr;
                    cur_cnt  <= base_cnt;
                end else begin
                    cur_addr <= mode_q.dec ? (cur_addr - ONE) : (cur_addr + ONE);
                    cur_cnt  <= cur_cnt - ONE;
                end
                if (finish && !mode_q.autoinit) begin
                    masked <= 1'b1;
                end
            end
        end
    end

    // Direction is consumed at the top through this view
    logic dir_unused;
    assign dir_unused = mode_q.dir;

endmodule

// File: rtl/dma4_prio.sv
module dma4_prio #(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic [N-1:0]  req,
    output logic [CW-1:0] idx,
    output logic          any
);

    // Lowest index wins: scan from the top so the lowest match is kept last
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = CW'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
    import dma4_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_any,
    input  logic       hlda,
    output logic       grab,
    output logic       idle,
    output logic       hrq,
    output logic       addr_ph,
    output logic       xfer_ph,
    output logic       upd_ph
);

    seq_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_any) state_nx = ST_REQ;
            ST_REQ:  if (hlda)    state_nx = ST_ADDR;
            ST_ADDR: state_nx = ST_XFER;
            ST_XFER: state_nx = ST_UPDT;
            ST_UPDT: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        idle    = (state == ST_IDLE);
        grab    = idle && req_any;
        hrq     = !idle;
        addr_ph = (state == ST_ADDR) || (state == ST_XFER);
        xfer_ph = (state == ST_XFER);
        upd_ph  = (state == ST_UPDT);
    end

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SELW-1:0]   host_sel,
    input  logic [DW-1:0]     host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [DW-1:0]     host_rdata,
    input  logic [NCH-1:0]    dreq,
    output logic              hrq,
    input  logic              hlda,
    output logic [NCH-1:0]    dack,
    output logic [2*DW-1:0]   dma_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    input  logic              eop_in_n,
    output logic              eop_out
);

    localparam int AW = 2 * DW;

    logic            idle, grab, addr_ph, xfer_ph, upd_ph;
    logic            req_any;
    logic [CHW-1:0]  win_idx;
    logic [CHW-1:0]  act_ch;
    logic            byte_ff;
    logic [NCH-1:0]  mask_q;
    logic [NCH-1:0]  tc_v;
    logic [AW-1:0]   cur_addr_a [NCH];
    logic [AW-1:0]   cur_cnt_a  [NCH];
    chan_mode_t      mode_a     [NCH];
    chan_mode_t      mode_in;

    // Host decode
    logic            reg_hit;
    logic [CHW-1:0]  sel_ch;
    logic            sel_cnt;
    logic            host_wr_ok;
    logic            host_rd_ok;

    assign reg_hit    = !host_sel[SELW-1];
    assign sel_ch     = host_sel[CHW:1];
    assign sel_cnt    = host_sel[0];
    assign host_wr_ok = idle && host_wr;
    assign host_rd_ok = idle && host_rd;
    assign mode_in    = '{autoinit: host_wdata[4], dec: host_wdata[3], dir: host_wdata[2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_ff <= 1'b0;
        end else if (host_wr_ok && host_sel == SEL_CLRFF) begin
            byte_ff <= 1'b0;
        end else if ((host_wr_ok || host_rd_ok) && reg_hit) begin
            byte_ff <= !byte_ff;
        end
    end

    // Priority and sequencer
    dma4_prio #(.N(NCH), .CW(CHW)) u_prio (
        .req (dreq & ~mask_q),
        .idx (win_idx),
        .any (req_any)
    );

    dma4_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .req_any (req_any),
        .hlda    (hlda),
        .grab    (grab),
        .idle    (idle),
        .hrq     (hrq),
        .addr_ph (addr_ph),
        .xfer_ph (xfer_ph),
        .upd_ph  (upd_ph)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_ch <= '0;
        end else if (grab) begin
            act_ch <= win_idx;
        end
    end

    logic finish;
    assign finish = tc_v[act_ch] || !eop_in_n;

    // Channel register sets
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic wr_a, wr_c, m_we, k_we, k_in, stp;
        assign wr_a = host_wr_ok && reg_hit && sel_ch == CHW'(g) && !sel_cnt;
        assign wr_c = host_wr_ok && reg_hit && sel_ch == CHW'(g) &&  sel_cnt;
        assign m_we = host_wr_ok && host_sel == SEL_MODE && host_wdata[CHW-1:0] == CHW'(g);
        assign k_we = host_wr_ok && ((host_sel == SEL_MASK1 && host_wdata[CHW-1:0] == CHW'(g))
                                     || host_sel == SEL_MASKALL);
        assign k_in = (host_sel == SEL_MASKALL) ? host_wdata[g] : host_wdata[2];
        assign stp  = upd_ph && act_ch == CHW'(g);

        dma4_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .hi_byte  (byte_ff),
            .wr_addr  (wr_a),
            .wr_cnt   (wr_c),
            .wdata    (host_wdata),
            .mode_we  (m_we),
            .mode_in  (mode_in),
            .mask_we  (k_we),
            .mask_in  (k_in),
            .step     (stp),
            .finish   (finish),
            .cur_addr (cur_addr_a[g]),
            .cur_cnt  (cur_cnt_a[g]),
            .tc       (tc_v[g]),
            .masked   (mask_q[g])
        );

        // Mode is held inside the channel; a shadow copy keeps direction at the top
        always_ff @(posedge clk) begin
            if (rst) begin
                mode_a[g] <= '0;
            end else if (m_we) begin
                mode_a[g] <= mode_in;
            end
        end
    end

    // Bus-side outputs
    always_comb begin
        dack     = '0;
        dma_addr = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        if (addr_ph) begin
            dack[act_ch] = 1'b1;
            dma_addr     = cur_addr_a[act_ch];
        end
        if (xfer_ph) begin
            if (mode_a[act_ch].dir) begin
                mem_rd = 1'b1;
                io_wr  = 1'b1;
            end else begin
                io_rd  = 1'b1;
                mem_wr = 1'b1;
            end
        end
        eop_out = upd_ph && tc_v[act_ch];
    end

    // Host read data
    logic [AW-1:0] rd_word;
    always_comb begin
        rd_word    = sel_cnt ? cur_cnt_a[sel_ch] : cur_addr_a[sel_ch];
        host_rdata = '0;
        if (idle) begin
            if (reg_hit) begin
                host_rdata = byte_ff ? rd_word[AW-1:DW] : rd_word[DW-1:0];
            end else if (host_sel == SEL_MASKRD) begin
                host_rdata[NCH-1:0] = mask_q;
            end
        end
    end

endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] dreq,
    input logic [NCH-1:0] mask,
    input logic           hlda,
    input logic           hrq,
    input logic [NCH-1:0] dack,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           io_rd,
    input logic           io_wr,
    input logic           eop_out
);

    p_dack_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    p_masked_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(hrq) |-> $past(|(dreq & ~mask)));

    p_strobe_pair_r3: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr) && !(io_rd && io_wr) && !(mem_rd && io_rd));

    p_dack_under_hrq_r4: assert property (@(posedge clk) disable iff (rst)
        (|dack) |-> hrq);

    p_dack_after_hlda_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(|dack) |-> $past(hlda));

    p_addr_then_xfer_r4: assert property (@(posedge clk) disable iff (rst)
        ((|dack) && !(mem_rd || mem_wr)) |=> ((mem_rd || mem_wr) && $stable(dack)));

    p_eop_one_clock_r7: assert property (@(posedge clk) disable iff (rst)
        eop_out |=> !eop_out);

endmodule

bind dma4_ctrl dma4_ctrl_chk #(.NCH(dma4_pkg::NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .dreq    (dreq),
    .mask    (mask_q),
    .hlda    (hlda),
    .hrq     (hrq),
    .dack    (dack),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .eop_out (eop_out)
);

// File: tb/dma4_ctrl_test.sv
module dma4_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  host_sel;
    logic [7:0]  host_wdata;
    logic        host_wr, host_rd;
    logic [7:0]  host_rdata;
    logic [3:0]  dreq;
    logic        hrq, hlda;
    logic [3:0]  dack;
    logic [15:0] dma_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr;
    logic        eop_in_n, eop_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dma4_ctrl uut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .dreq(dreq), .hrq(hrq), .hlda(hlda), .dack(dack), .dma_addr(dma_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .eop_in_n(eop_in_n), .eop_out(eop_out)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [15:0] base;
        logic [15:0] cnt;
        logic [2:0]  mode;   // {autoreload, decrement, direction}
        logic [3:0]  nx;
        logic [15:0] ex_addr;
        logic [15:0] ex_cnt;
        logic        ex_mask;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{2'd0, 16'h1000, 16'd2, 3'b000, 4'd3, 16'h1003, 16'hFFFF, 1'b1},
        '{2'd1, 16'h2005, 16'd1, 3'b011, 4'd2, 16'h2003, 16'hFFFF, 1'b1},
        '{2'd2, 16'h30FF, 16'd1, 3'b100, 4'd2, 16'h30FF, 16'h0001, 1'b0},
        '{2'd3, 16'h0000, 16'd0, 3'b011, 4'd1, 16'hFFFF, 16'hFFFF, 1'b1},
        '{2'd2, 16'h4000, 16'd5, 3'b001, 4'd2, 16'h4002, 16'h0003, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [3:0] sel, output logic [7:0] d);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] sel, input logic [15:0] v);
        hw(4'd11, 8'h00);
        hw(sel, v[7:0]);
        hw(sel, v[15:8]);
    endtask

    task automatic rd16(input logic [3:0] sel, output logic [15:0] v);
        logic [7:0] lo, hi;
        hw(4'd11, 8'h00);
        hr(sel, lo);
        hr(sel, hi);
        v = {hi, lo};
    endtask

    task automatic req_phase(input int ch);
        @(negedge clk);
        dreq[ch] = 1'b1;
        @(negedge clk);
        chk("R4 hold request raised", 32'(hrq), 32'd1);
    endtask

    task automatic xfer_phase(input int ch, input logic [15:0] ea, input logic dir, input logic eeop);
        hlda = 1'b1;
        @(negedge clk);                                  // ADDR
        chk("R4 acknowledge in address state", 32'(dack), 32'(4'b1 << ch));
        chk("R6 address driven", 32'(dma_addr), 32'(ea));
        chk("R4 no strobe in address state", 32'({mem_rd, mem_wr, io_rd, io_wr}), 32'd0);
        @(negedge clk);                                  // XFER
        chk("R3 strobe pattern", 32'({mem_rd, mem_wr, io_rd, io_wr}),
            dir ? 32'b1001 : 32'b0110);
        chk("R5 single acknowledge", 32'(dack), 32'(4'b1 << ch));
        dreq[ch] = 1'b0;
        @(negedge clk);                                  // UPDT
        chk("R7 end-of-process pulse", 32'(eop_out), 32'(eeop));
        chk("R4 acknowledge dropped in update", 32'(dack), 32'd0);
        hlda = 1'b0;
        @(negedge clk);                                  // IDLE
        chk("R4 hold request released", 32'(hrq), 32'd0);
        chk("R7 pulse lasts one clock", 32'(eop_out), 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL R4 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v16;
        logic [7:0]  v8;
        rst = 1'b1; host_sel = '0; host_wdata = '0; host_wr = 1'b0; host_rd = 1'b0;
        dreq = '0; hlda = 1'b0; eop_in_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 hold request after reset", 32'(hrq), 32'd0);
        chk("R1 acknowledge after reset", 32'(dack), 32'd0);
        chk("R1 strobes after reset", 32'({mem_rd, mem_wr, io_rd, io_wr, eop_out}), 32'd0);
        hr(4'd12, v8);
        chk("R1 mask bits after reset", 32'(v8), 32'h0F);
        rd16(4'd2, v16);
        chk("R1 address cleared", 32'(v16), 32'd0);

        // R2 byte toggle and its clear command
        hw(4'd11, 8'h00);
        hw(4'd0, 8'hCD);
        hw(4'd11, 8'h00);
        hw(4'd0, 8'hAB);
        hw(4'd0, 8'h77);
        rd16(4'd0, v16);
        chk("R2 toggle clear reorders bytes", 32'(v16), 32'h77AB);

        // Vector table
        for (int r = 0; r < 5; r++) begin
            vec_t v;
            v = VEC[r];
            hw(4'd8, {3'b000, v.mode, v.ch});
            wr16({1'b0, v.ch, 1'b0}, v.base);
            wr16({1'b0, v.ch, 1'b1}, v.cnt);
            hw(4'd9, {5'b0, 1'b0, v.ch});
            for (int i = 0; i < int'(v.nx); i++) begin
                logic [15:0] ea;
                ea = v.mode[1] ? (v.base - 16'(i)) : (v.base + 16'(i));
                req_phase(int'(v.ch));
                xfer_phase(int'(v.ch), ea, v.mode[0], (32'(i) == 32'(v.cnt)));
            end
            rd16({1'b0, v.ch, 1'b0}, v16);
            chk("R6 R8 R9 address after run", 32'(v16), 32'(v.ex_addr));
            rd16({1'b0, v.ch, 1'b1}, v16);
            chk("R7 R8 R9 count after run", 32'(v16), 32'(v.ex_cnt));
            hr(4'd12, v8);
            chk("R8 R9 mask after run", 32'(v8[v.ch]), 32'(v.ex_mask));
        end

        // R5 priority: channels 1 and 2 both request
        hw(4'd10, 8'h09);
        @(negedge clk);
        dreq = 4'b0110;
        @(negedge clk);
        chk("R5 hold request on two requests", 32'(hrq), 32'd1);
        xfer_phase(1, 16'h2003, 1'b1, 1'b0);
        @(negedge clk);
        chk("R5 lower channel served next", 32'(hrq), 32'd1);
        xfer_phase(2, 16'h4002, 1'b1, 1'b0);

        // R5 masked requests ignored
        hw(4'd10, 8'h0F);
        @(negedge clk);
        dreq = 4'b1111;
        repeat (6) @(negedge clk);
        chk("R5 masked requests ignored", 32'({hrq, dack}), 32'd0);
        dreq = 4'b0000;

        // R10 external end of process without auto-reload
        hw(4'd8, 8'h00);
        wr16(4'd0, 16'h5000);
        wr16(4'd1, 16'd9);
        hw(4'd9, 8'h00);
        eop_in_n = 1'b0;
        req_phase(0);
        xfer_phase(0, 16'h5000, 1'b0, 1'b0);
        eop_in_n = 1'b1;
        rd16(4'd0, v16);
        chk("R10 address stepped", 32'(v16), 32'h5001);
        rd16(4'd1, v16);
        chk("R10 count stepped", 32'(v16), 32'd8);
        hr(4'd12, v8);
        chk("R10 mask set by external end", 32'(v8), 32'h0F);

        // R10 external end of process with auto-reload
        hw(4'd8, 8'h13);
        wr16(4'd6, 16'h6000);
        wr16(4'd7, 16'd9);
        hw(4'd9, 8'h03);
        eop_in_n = 1'b0;
        req_phase(3);
        xfer_phase(3, 16'h6000, 1'b0, 1'b0);
        eop_in_n = 1'b1;
        rd16(4'd6, v16);
        chk("R9 R10 address reloaded", 32'(v16), 32'h6000);
        rd16(4'd7, v16);
        chk("R9 R10 count reloaded", 32'(v16), 32'd9);
        hr(4'd12, v8);
        chk("R9 R10 mask stays clear", 32'(v8), 32'h07);

        // R11 host writes while holding the bus
        req_phase(3);
        hw(4'd6, 8'hAA);
        hw(4'd10, 8'h00);
        xfer_phase(3, 16'h6000, 1'b0, 1'b0);
        rd16(4'd6, v16);
        chk("R11 address write ignored while busy", 32'(v16), 32'h6001);
        hr(4'd12, v8);
        chk("R11 mask write ignored while busy", 32'(v8), 32'h07);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule